// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the four arithmetic status flags of an 8-bit processor: sign (N), signed overflow (V), zero (Z) and carry (C). Each flag sits in its own register with its own load strobe. A single source-select line decides whether V, Z and C take their next value from the data bus, as when a saved status byte is restored, or from logic that computes them. N always copies the bus sign bit.

The computed values are built inside the block. Zero is judged on whatever value crosses the bus, so a register transfer can set it as well as an ALU result. Overflow is judged from the sign bits of the two operands and of the result. Carry comes from one of four selectable sources.

The block also places the flags onto the bus so that status can be saved. It supplies the carry-in used by the shifter and by the ALU, which is either the stored carry or a forced constant. The ALU, the shifter and the sequencer sit outside; their signals arrive as plain inputs.

Top module: `status_flag_unit`

## Requirements
- R1: With `src_comp` low, a load of V, Z or C takes bus bit 6, bit 1 or bit 0 respectively. With `src_comp` high, the same loads take the computed values instead.
- R2: A load of N always takes bus bit 7, whatever the level of `src_comp`.
- R3: The computed Z is 1 exactly when all eight bus bits are 0.
- R4: Each of `ld_n`, `ld_v`, `ld_z` and `ld_c` updates only its own flag, on a rising clock edge. Any mix of them may be active in one cycle. A flag whose strobe is low keeps its value.
- R5: The computed C follows `csel`: 0 gives `alu_cout`, 1 gives the inverse of `alu_cout`, 2 gives `shf_msb`, 3 gives `shf_lsb`.
- R6: The computed V depends on {`opc_bit1`,`opc_bit3`}. For addition, {0,1}, V is 1 when both operand signs match and the result sign differs from them. For subtraction, {1,0}, V is 1 when the operand signs differ and the result sign differs from operand A. For {0,0} and {1,1}, V is 0.
- R7: `cin_sel` sets `shf_cin`: 0 gives the stored C, 1 gives 0, 2 gives 1, and the unused code 3 gives 0. `alu_cin_n` is always the inverse of `shf_cin`. The bench treats code 3 as an illegal input.
- R8: A low `rst_n` clears all four flags at once, without waiting for a clock. After `rst_n` rises, loads on the first two rising edges are ignored; the third edge is the first that loads.
- R9: With `flag_oe` high, `bus_out` carries N on bit 7, V on bit 6, Z on bit 1 and C on bit 0, with every other bit 0. With `flag_oe` low, `bus_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | DATA_W | Value currently on the data bus |
| bus_out | output | DATA_W | Status byte driven toward the bus |
| flag_oe | input | 1 | Enables the status byte on `bus_out` |
| src_comp | input | 1 | 1: V/Z/C from computed values, 0: from the bus |
| ld_n | input | 1 | Load strobe for N |
| ld_v | input | 1 | Load strobe for V |
| ld_z | input | 1 | Load strobe for Z |
| ld_c | input | 1 | Load strobe for C |
| opa_msb | input | 1 | Sign bit of operand A |
| opb_msb | input | 1 | Sign bit of operand B |
| res_msb | input | 1 | Sign bit of the ALU result |
| opc_bit1 | input | 1 | Opcode bit 1 (subtract indication) |
| opc_bit3 | input | 1 | Opcode bit 3 (add indication) |
| alu_cout | input | 1 | Raw ALU carry-out |
| shf_msb | input | 1 | Shifter register bit 7 |
| shf_lsb | input | 1 | Shifter register bit 0 |
| csel | input | 2 | Computed carry source code |
| cin_sel | input | 2 | Carry-in code: bit 1 forces one, bit 0 forces zero |
| shf_cin | output | 1 | Carry-in to the shifter |
| alu_cin_n | output | 1 | Carry-in to the ALU, inverted |
| flag_n | output | 1 | Stored sign flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |

## Verification
Two things can happen in the same cycle: restoring the carry from the bus, and handing the stored carry to the shifter and the ALU with `cin_sel` at 0. The bench provokes this by loading C from a toggling bus bit on each cycle, while it steps `cin_sel` through all four codes. `shf_cin` must show the old carry until the edge and the new one after it. A second case drives `flag_oe` while all four flags reload from the very byte being driven, so a restore has to leave the status unchanged. A behavioural model judges each cycle at the falling edge, including the two ignored edges after reset release.

// File: rtl/flag_pkg.sv
package flag_pkg;

  // Flag vector index order used throughout the unit
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned IDX_C     = 0;
  localparam int unsigned IDX_Z     = 1;
  localparam int unsigned IDX_V     = 2;
  localparam int unsigned IDX_N     = 3;

  // Which flags may take a computed value (N never does)
  localparam logic [NUM_FLAGS-1:0] COMPUTABLE = 4'b0111;

  typedef enum logic [1:0] {
    CY_ALU_RAW = 2'b00,
    CY_ALU_INV = 2'b01,
    CY_SHF_HI  = 2'b10,
    CY_SHF_LO  = 2'b11
  } cy_src_e;

  typedef enum logic [1:0] {
    CI_STORED = 2'b00,
    CI_ZERO   = 2'b01,
    CI_ONE    = 2'b10,
    CI_RSVD   = 2'b11
  } cin_src_e;

  typedef enum logic [1:0] {
    AR_NONE = 2'b00,
    AR_ADD  = 2'b01,
    AR_SUB  = 2'b10,
    AR_BOTH = 2'b11
  } arith_kind_e;

endpackage

// File: rtl/flag_rst_sync.sv
module flag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/flag_compute.sv
module flag_compute
  import flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] bus_in,
  input  logic              opa_msb,
  input  logic              opb_msb,
  input  logic              res_msb,
  input  logic              opc_bit1,
  input  logic              opc_bit3,
  input  logic              alu_cout,
  input  logic              shf_msb,
  input  logic              shf_lsb,
  input  logic [1:0]        csel,
  output logic              comp_v,
  output logic              comp_z,
  output logic              comp_c
);

  arith_kind_e kind;
  cy_src_e     cy_src;
  logic        sign_flip;
  logic        ops_alike;

  assign kind   = arith_kind_e'({opc_bit1, opc_bit3});
  assign cy_src = cy_src_e'(csel);

  // Zero: any value that crosses the bus
  always_comb begin
    comp_z = ~(|bus_in);
  end

  // Overflow: sign of the result moved away from operand A
  always_comb begin
    sign_flip = res_msb ^ opa_msb;
    ops_alike = ~(opa_msb ^ opb_msb);
    unique case (kind)
      AR_ADD:  comp_v = sign_flip &  ops_alike;
      AR_SUB:  comp_v = sign_flip & ~ops_alike;
      default: comp_v = 1'b0;
    endcase
  end

  // Carry source selection
  always_comb begin
    unique case (cy_src)
      CY_ALU_RAW: comp_c = alu_cout;
      CY_ALU_INV: comp_c = ~alu_cout;
      CY_SHF_HI:  comp_c = shf_msb;
      CY_SHF_LO:  comp_c = shf_lsb;
      default:    comp_c = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import flag_pkg::*;
#(
  parameter int unsigned          NUM       = NUM_FLAGS,
  parameter logic [NUM-1:0]       COMP_MASK = COMPUTABLE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           src_comp,
  input  logic [NUM-1:0] ld,
  input  logic [NUM-1:0] bus_val,
  input  logic [NUM-1:0] comp_val,
  output logic [NUM-1:0] q
);

  logic [NUM-1:0] sel_val;

  // Per-flag source: computed only where the mask allows it
  always_comb begin
    if (src_comp) begin
      sel_val = (comp_val & COMP_MASK) | (bus_val & ~COMP_MASK);
    end else begin
      sel_val = bus_val;
    end
  end

  for (genvar i = 0; i < NUM; i++) begin : g_cell
    logic cell_q;
    logic cell_d;

    always_comb begin
      cell_d = cell_q;
      if (ld[i]) begin
        cell_d = sel_val[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 1'b0;
      end else begin
        cell_q <= cell_d;
      end
    end

    assign q[i] = cell_q;
  end

endmodule

// File: rtl/flag_export.sv
module flag_export
  import flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_N  = DATA_W - 1,
  parameter int unsigned POS_V  = DATA_W - 2,
  parameter int unsigned POS_Z  = 1,
  parameter int unsigned POS_C  = 0
) (
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic                 flag_oe,
  input  logic [1:0]           cin_sel,
  output logic [DATA_W-1:0]    bus_out,
  output logic                 shf_cin,
  output logic                 alu_cin_n
);

  cin_src_e cin_src;
  logic     cin_val;

  assign cin_src = cin_src_e'(cin_sel);

  // Carry-in: stored flag or forced constant; reserved code reads as zero
  always_comb begin
    unique case (cin_src)
      CI_STORED: cin_val = flags[IDX_C];
      CI_ONE:    cin_val = 1'b1;
      CI_ZERO:   cin_val = 1'b0;
      default:   cin_val = 1'b0;
    endcase
  end

  assign shf_cin   = cin_val;
  assign alu_cin_n = ~cin_val;

  // Status byte; unused positions stay low
  always_comb begin
    bus_out = '0;
    if (flag_oe) begin
      bus_out[POS_N] = flags[IDX_N];
      bus_out[POS_V] = flags[IDX_V];
      bus_out[POS_Z] = flags[IDX_Z];
      bus_out[POS_C] = flags[IDX_C];
    end
  end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import flag_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  input  logic              flag_oe,
  input  logic              src_comp,
  input  logic              ld_n,
  input  logic              ld_v,
  input  logic              ld_z,
  input  logic              ld_c,
  input  logic              opa_msb,
  input  logic              opb_msb,
  input  logic              res_msb,
  input  logic              opc_bit1,
  input  logic              opc_bit3,
  input  logic              alu_cout,
  input  logic              shf_msb,
  input  logic              shf_lsb,
  input  logic [1:0]        csel,
  input  logic [1:0]        cin_sel,
  output logic              shf_cin,
  output logic              alu_cin_n,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c
);

  localparam int unsigned POS_N = DATA_W - 1;
  localparam int unsigned POS_V = DATA_W - 2;
  localparam int unsigned POS_Z = 1;
  localparam int unsigned POS_C = 0;

  logic                 rst_q_n;
  logic                 comp_v;
  logic                 comp_z;
  logic                 comp_c;
  logic [NUM_FLAGS-1:0] ld_vec;
  logic [NUM_FLAGS-1:0] bus_vec;
  logic [NUM_FLAGS-1:0] comp_vec;
  logic [NUM_FLAGS-1:0] flag_q;

  flag_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  flag_compute #(
    .DATA_W (DATA_W)
  ) u_compute (
    .bus_in   (bus_in),
    .opa_msb  (opa_msb),
    .opb_msb  (opb_msb),
    .res_msb  (res_msb),
    .opc_bit1 (opc_bit1),
    .opc_bit3 (opc_bit3),
    .alu_cout (alu_cout),
    .shf_msb  (shf_msb),
    .shf_lsb  (shf_lsb),
    .csel     (csel),
    .comp_v   (comp_v),
    .comp_z   (comp_z),
    .comp_c   (comp_c)
  );

  always_comb begin
    ld_vec   = '0;
    bus_vec  = '0;
    comp_vec = '0;
    ld_vec[IDX_N]   = ld_n;
    ld_vec[IDX_V]   = ld_v;
    ld_vec[IDX_Z]   = ld_z;
    ld_vec[IDX_C]   = ld_c;
    bus_vec[IDX_N]  = bus_in[POS_N];
    bus_vec[IDX_V]  = bus_in[POS_V];
    bus_vec[IDX_Z]  = bus_in[POS_Z];
    bus_vec[IDX_C]  = bus_in[POS_C];
    comp_vec[IDX_N] = bus_in[POS_N];
    comp_vec[IDX_V] = comp_v;
    comp_vec[IDX_Z] = comp_z;
    comp_vec[IDX_C] = comp_c;
  end

  flag_bank #(
    .NUM       (NUM_FLAGS),
    .COMP_MASK (COMPUTABLE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .src_comp (src_comp),
    .ld       (ld_vec),
    .bus_val  (bus_vec),
    .comp_val (comp_vec),
    .q        (flag_q)
  );

  flag_export #(
    .DATA_W (DATA_W),
    .POS_N  (POS_N),
    .POS_V  (POS_V),
    .POS_Z  (POS_Z),
    .POS_C  (POS_C)
  ) u_export (
    .flags     (flag_q),
    .flag_oe   (flag_oe),
    .cin_sel   (cin_sel),
    .bus_out   (bus_out),
    .shf_cin   (shf_cin),
    .alu_cin_n (alu_cin_n)
  );

  assign flag_n = flag_q[IDX_N];
  assign flag_v = flag_q[IDX_V];
  assign flag_z = flag_q[IDX_Z];
  assign flag_c = flag_q[IDX_C];

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q_n,
  input logic [DATA_W-1:0] bus_in,
  input logic [DATA_W-1:0] bus_out,
  input logic              flag_oe,
  input logic              src_comp,
  input logic              ld_n,
  input logic              ld_v,
  input logic              ld_z,
  input logic              ld_c,
  input logic [1:0]        cin_sel,
  input logic              shf_cin,
  input logic              alu_cin_n,
  input logic              flag_n,
  input logic              flag_v,
  input logic              flag_z,
  input logic              flag_c
);

  // R1: bus-sourced overflow load
  p_v_from_bus_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_v && !src_comp) |=> (flag_v == $past(bus_in[DATA_W-2])));

  // R2: sign flag tracks the bus sign bit
  p_n_from_bus_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_n |=> (flag_n == $past(bus_in[DATA_W-1])));

  // R3: computed zero
  p_z_computed_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_z && src_comp) |=> (flag_z == ($past(bus_in) == '0)));

  // R4: idle strobes hold their flags
  p_hold_n_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_n |=> $stable(flag_n));
  p_hold_v_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_v |=> $stable(flag_v));
  p_hold_z_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_z |=> $stable(flag_z));
  p_hold_c_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld_c |=> $stable(flag_c));

  // R7: carry-in forcing and the inverted ALU copy
  p_cin_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cin_sel[0] |-> !shf_cin);
  p_cin_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_sel == 2'b10) |-> shf_cin);
  p_cin_stored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_sel == 2'b00) |-> (shf_cin == flag_c));
  p_alu_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_cin_n != shf_cin);

  // R8: reset clears everything
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |-> ({flag_n, flag_v, flag_z, flag_c} == 4'b0000));

  // R9: status byte layout and quiet bus
  p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_oe |-> (bus_out == '0));
  p_bus_layout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_oe |-> (bus_out[DATA_W-1] == flag_n && bus_out[DATA_W-2] == flag_v &&
                 bus_out[1] == flag_z && bus_out[0] == flag_c &&
                 bus_out[DATA_W-3:2] == '0));

endmodule

bind status_flag_unit flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q_n   (rst_q_n),
  .bus_in    (bus_in),
  .bus_out   (bus_out),
  .flag_oe   (flag_oe),
  .src_comp  (src_comp),
  .ld_n      (ld_n),
  .ld_v      (ld_v),
  .ld_z      (ld_z),
  .ld_c      (ld_c),
  .cin_sel   (cin_sel),
  .shf_cin   (shf_cin),
  .alu_cin_n (alu_cin_n),
  .flag_n    (flag_n),
  .flag_v    (flag_v),
  .flag_z    (flag_z),
  .flag_c    (flag_c)
);

// File: tb/status_flag_unit_bench.sv
module status_flag_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_in;
  logic [7:0] bus_out;
  logic       flag_oe, src_comp;
  logic       ld_n, ld_v, ld_z, ld_c;
  logic       opa_msb, opb_msb, res_msb, opc_bit1, opc_bit3;
  logic       alu_cout, shf_msb, shf_lsb;
  logic [1:0] csel, cin_sel;
  logic       shf_cin, alu_cin_n;
  logic       flag_n, flag_v, flag_z, flag_c;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    n_ill  = 0;
  string cur_req = "R8";
  bit    done    = 1'b0;

  // reference state
  bit m_n, m_v, m_z, m_c;
  int rel_cnt = 0;

  always #4 clk = ~clk;

  status_flag_unit u_status_flag_unit (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .flag_oe(flag_oe), .src_comp(src_comp),
    .ld_n(ld_n), .ld_v(ld_v), .ld_z(ld_z), .ld_c(ld_c),
    .opa_msb(opa_msb), .opb_msb(opb_msb), .res_msb(res_msb),
    .opc_bit1(opc_bit1), .opc_bit3(opc_bit3),
    .alu_cout(alu_cout), .shf_msb(shf_msb), .shf_lsb(shf_lsb),
    .csel(csel), .cin_sel(cin_sel),
    .shf_cin(shf_cin), .alu_cin_n(alu_cin_n),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
  );

  // ---------------- reference model ----------------
  always @(negedge rst_n) begin
    m_n = 0; m_v = 0; m_z = 0; m_c = 0; rel_cnt = 0;
  end

  always @(posedge clk) begin
    bit ov, zr, cy;
    int a, b, r;
    if (rst_n !== 1'b1) begin
      m_n = 0; m_v = 0; m_z = 0; m_c = 0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      a = opa_msb ? -1 : 1;
      b = opb_msb ? -1 : 1;
      r = res_msb ? -1 : 1;
      ov = 0;
      if (!opc_bit1 && opc_bit3) ov = (a * b > 0) && (r * a < 0);
      else if (opc_bit1 && !opc_bit3) ov = (a * b < 0) && (r * a < 0);
      zr = (bus_in == 8'd0);
      case (csel)
        2'd0: cy = alu_cout;
        2'd1: cy = !alu_cout;
        2'd2: cy = shf_msb;
        default: cy = shf_lsb;
      endcase
      if (ld_n) m_n = bus_in[7];
      if (ld_v) m_v = src_comp ? ov : bus_in[6];
      if (ld_z) m_z = src_comp ? zr : bus_in[1];
      if (ld_c) m_c = src_comp ? cy : bus_in[0];
    end
    if (rst_n === 1'b1 && cin_sel == 2'b11) begin
      n_ill++;
      if (n_ill <= 3) $display("NOTE: illegal carry-in code 11 driven (%s)", cur_req);
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    bit       e_cin;
    bit [7:0] e_bus;
    if (!done && $time > 6) begin
      e_cin = (cin_sel == 2'b00) ? m_c : (cin_sel == 2'b10);
      e_bus = flag_oe ? {m_n, m_v, 4'b0000, m_z, m_c} : 8'h00;
      chk("flag_n", {7'd0, flag_n}, {7'd0, m_n});
      chk("flag_v", {7'd0, flag_v}, {7'd0, m_v});
      chk("flag_z", {7'd0, flag_z}, {7'd0, m_z});
      chk("flag_c", {7'd0, flag_c}, {7'd0, m_c});
      chk("shf_cin", {7'd0, shf_cin}, {7'd0, e_cin});
      chk("alu_cin_n", {7'd0, alu_cin_n}, {7'd0, !e_cin});
      chk("bus_out", bus_out, e_bus);
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    {ld_n, ld_v, ld_z, ld_c} = 4'b0000;
    flag_oe = 0; src_comp = 0; bus_in = 8'h00;
    {opa_msb, opb_msb, res_msb, opc_bit1, opc_bit3} = 5'b0;
    {alu_cout, shf_msb, shf_lsb} = 3'b0;
    csel = 2'd0; cin_sel = 2'd0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    byte pat_r1 [4] = '{8'h43, 8'h02, 8'h00, 8'hBD};
    byte pat_r2 [4] = '{8'h80, 8'h7F, 8'hFF, 8'h00};
    byte pat_r3 [5] = '{8'h00, 8'h01, 8'h80, 8'h00, 8'h40};
    idle();
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    // R8: reset state, then loads during release must be ignored for two edges
    cur_req = "R8";
    repeat (3) tick();
    {ld_n, ld_v, ld_z, ld_c} = 4'b1111;
    bus_in = 8'hFF;
    rst_n = 1'b1;
    repeat (4) tick();
    idle();
    tick();

    // R1: bus source for V/Z/C at bits 6/1/0, then computed source
    cur_req = "R1";
    src_comp = 0; {ld_v, ld_z, ld_c} = 3'b111;
    foreach (pat_r1[i]) begin bus_in = pat_r1[i]; tick(); end
    src_comp = 1; alu_cout = 1; opc_bit3 = 1; res_msb = 1;
    bus_in = 8'h02; tick();
    idle(); tick();

    // R2: N from bit 7 under both source levels
    cur_req = "R2";
    ld_n = 1;
    foreach (pat_r2[i]) begin src_comp = i[0]; bus_in = pat_r2[i]; tick(); end
    idle(); tick();

    // R3: computed zero
    cur_req = "R3";
    src_comp = 1; ld_z = 1;
    foreach (pat_r3[i]) begin bus_in = pat_r3[i]; tick(); end
    idle(); tick();

    // R5: all carry sources
    cur_req = "R5";
    src_comp = 1; ld_c = 1;
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 4; x++) begin
        csel = s[1:0];
        alu_cout = x[0]; shf_msb = x[1]; shf_lsb = ~x[0];
        tick();
      end
    end
    idle(); tick();

    // R6: every sign combination under every arithmetic code
    cur_req = "R6";
    src_comp = 1; ld_v = 1;
    for (int op = 0; op < 4; op++) begin
      for (int m = 0; m < 8; m++) begin
        {opc_bit1, opc_bit3} = op[1:0];
        {opa_msb, opb_msb, res_msb} = m[2:0];
        tick();
      end
    end
    idle(); tick();

    // R7: carry restore from bus coinciding with each carry-in code
    cur_req = "R7";
    src_comp = 0; ld_c = 1;
    for (int k = 0; k < 16; k++) begin
      bus_in = {7'd0, k[0]};
      cin_sel = k[2:1];
      tick();
    end
    idle(); tick();

    // R9: status byte layout, and restore of the byte being driven
    cur_req = "R9";
    for (int k = 0; k < 16; k++) begin
      src_comp = 0; {ld_n, ld_v, ld_z, ld_c} = 4'b1111;
      bus_in = {k[3], k[2], 4'b1111, k[1], k[0]};
      flag_oe = k[0] | k[3];
      tick();
    end
    {ld_n, ld_v, ld_z, ld_c} = 4'b0000;
    flag_oe = 1;
    tick();
    for (int k = 0; k < 4; k++) begin
      {ld_n, ld_v, ld_z, ld_c} = 4'b1111;
      bus_in = bus_out;
      tick();
    end
    idle(); tick();

    // R4: random mixes of strobes and sources
    cur_req = "R4";
    for (int k = 0; k < 400; k++) begin
      bus_in = 8'($urandom);
      {ld_n, ld_v, ld_z, ld_c} = 4'($urandom);
      {flag_oe, src_comp} = 2'($urandom);
      {opa_msb, opb_msb, res_msb, opc_bit1, opc_bit3} = 5'($urandom);
      {alu_cout, shf_msb, shf_lsb} = 3'($urandom);
      csel = 2'($urandom);
      cin_sel = 2'($urandom % 3);
      tick();
    end

    // R8: reset mid-run after setting all flags
    cur_req = "R8";
    idle();
    {ld_n, ld_v, ld_z, ld_c} = 4'b1111; bus_in = 8'hC3;
    tick();
    flag_oe = 1;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    repeat (5) tick();
    idle(); tick();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule